// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a small on-chip memory with one write port and one synchronous read port. The memory is organised as `DEPTH` native words of `WORD_W` bits. Either port can be narrower than the native word, by a power-of-two factor. A narrow port uses a wider address. The extra low-order address bits pick which slice of the stored word the port touches, and slice 0 is the least significant slice.

The write port has an enable and a lane mask. The mask splits the write data into equal lanes. The read port has an enable and a registered output. A run-time mode input sets what a read returns when it hits the word being written in the same cycle: the stored contents before the write, or the word after the write with the new bits merged in. In the remaining mode the colliding value is unspecified.

The default configuration has 16 words of 32 bits. It has an 8-bit write port (two address bits for the slice), a 16-bit read port (one address bit for the slice) and a 2-lane write mask, with 4 bits in each lane.

Top module: `mwram_sdp`

## Requirements
- R1: After reset is released, `rd_data_o` is zero and every stored word reads back as zero.
- R2: A write changes only the `WR_W`-bit slice selected by the low `WR_K` bits of `wr_addr_i` (slice 0 = bits [WR_W-1:0]) in the word selected by the upper address bits. All other bits of the memory keep their contents.
- R3: Mask bit j of `wr_mask_i` enables data lane j of the write, which is bits [j*LANE_W +: LANE_W] of `wr_data_i` with bit 0 as lane 0. A disabled lane leaves its stored bits unchanged.
- R4: When `wr_en_i` is low, the memory contents do not change, whatever the other write inputs are.
- R5: A read returns the `RD_W`-bit slice selected by the low `RD_K` bits of `rd_addr_i` (slice 0 = bits [RD_W-1:0]) of the word selected by the upper address bits.
- R6: Read data appears on `rd_data_o` in the cycle after a rising clock edge that samples `rd_en_i` high. While `rd_en_i` is sampled low, `rd_data_o` holds its value.
- R7: With `ruw_mode_i` = 0 (old data), a read of the word being written in the same cycle returns the contents from before the write. The next read returns the updated contents.
- R8: With `ruw_mode_i` = 1 (new data), a colliding read returns the written lanes merged with the unchanged old bits of the word.
- R9: With `ruw_mode_i` = 2 or 3 (don't care), the colliding read value is unspecified, but the write still completes and later reads see it.
- R10: A write to a different word in the same cycle as a read never alters that read's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | WR_AW | Write address, which is the word index followed by the slice index |
| wr_data_i | input | WR_W | Write data |
| wr_mask_i | input | WR_MASK_W | Per-lane write enable |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | RD_AW | Read address, which is the word index followed by the slice index |
| ruw_mode_i | input | 2 | Read-under-write policy: 0 old, 1 new, 2 or 3 don't care |
| rd_data_o | output | RD_W | Registered read data |

## Verification
A read and a write can target the same native word in one cycle. This case is the centre of the test. The bench provokes it by driving both enables in one cycle, with a read address whose word index equals the write's word index. It does this in old-data mode, in new-data mode, and in new-data mode with a partial lane mask. It judges the registered result against a shadow model. In that model the expected value is the word before the write, or the word after the lanes are merged, as the mode requires. A follow-up read without a collision confirms that the write completed. This also covers don't-care mode, where the colliding value itself is not checked.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  typedef enum logic [1:0] {
    RUW_OLD  = 2'd0,
    RUW_NEW  = 2'd1,
    RUW_DC_A = 2'd2,
    RUW_DC_B = 2'd3
  } ruw_e;
endpackage

// File: rtl/mwram_wr_align.sv
module mwram_wr_align #(
  parameter int WORD_W    = 32,
  parameter int WORD_AW   = 4,
  parameter int WR_K      = 2,
  parameter int WR_MASK_W = 2,
  localparam int WR_W     = WORD_W >> WR_K,
  localparam int WR_AW    = WORD_AW + WR_K,
  localparam int LANE_W   = WR_W / WR_MASK_W,
  localparam int SW       = (WR_K > 0) ? WR_K : 1
) (
  input  logic                 wr_en_i,
  input  logic [WR_AW-1:0]     wr_addr_i,
  input  logic [WR_W-1:0]      wr_data_i,
  input  logic [WR_MASK_W-1:0] wr_mask_i,
  output logic [WORD_AW-1:0]   word_addr_o,
  output logic [WORD_W-1:0]    bit_en_o,
  output logic [WORD_W-1:0]    data_o
);
  logic [SW-1:0]   slice;
  logic [WR_W-1:0] port_bits;
  logic [WORD_W-1:0] base;

  if (WR_K > 0) begin : g_sub
    assign slice       = wr_addr_i[WR_K-1:0];
    assign word_addr_o = wr_addr_i[WR_AW-1:WR_K];
  end else begin : g_full
    assign slice       = '0;
    assign word_addr_o = wr_addr_i;
  end

  for (genvar j = 0; j < WR_MASK_W; j++) begin : g_lane
    assign port_bits[j*LANE_W +: LANE_W] = {LANE_W{wr_mask_i[j]}};
  end

  always_comb begin
    base = '0;
    base[WR_W-1:0] = port_bits;
    bit_en_o = wr_en_i ? (base << (32'(slice) * WR_W)) : '0;
  end

  // same data replicated into every slice position
  assign data_o = {(1 << WR_K){wr_data_i}};
endmodule

// File: rtl/mwram_store.sv
module mwram_store #(
  parameter int WORD_W  = 32,
  parameter int DEPTH   = 16,
  localparam int WORD_AW = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WORD_AW-1:0] wr_word_i,
  input  logic [WORD_W-1:0]  bit_en_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [WORD_AW-1:0] rd_word_i,
  output logic [WORD_W-1:0]  rd_word_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (wr_word_i == WORD_AW'(w))
          mem_q[w] <= (mem_q[w] & ~bit_en_i) | (data_i & bit_en_i);
      end
    end
  end

  assign rd_word_o = mem_q[rd_word_i];
endmodule

// File: rtl/mwram_rd_port.sv
module mwram_rd_port
  import mwram_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int WORD_AW = 4,
  parameter int RD_K    = 1,
  localparam int RD_W   = WORD_W >> RD_K,
  localparam int RD_AW  = WORD_AW + RD_K,
  localparam int SW     = (RD_K > 0) ? RD_K : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [RD_AW-1:0]   rd_addr_i,
  input  logic [1:0]         ruw_mode_i,
  input  logic [WORD_AW-1:0] wr_word_i,
  input  logic [WORD_W-1:0]  bit_en_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [WORD_W-1:0]  old_word_i,
  output logic [WORD_AW-1:0] rd_word_o,
  output logic [RD_W-1:0]    rd_data_o
);
  logic [SW-1:0]     slice;
  logic              collide;
  logic [WORD_W-1:0] merged, chosen;
  logic [RD_W-1:0]   rd_data_q;
  logic [RD_W-1:0]   cur_slice;

  if (RD_K > 0) begin : g_sub
    assign slice     = rd_addr_i[RD_K-1:0];
    assign rd_word_o = rd_addr_i[RD_AW-1:RD_K];
  end else begin : g_full
    assign slice     = '0;
    assign rd_word_o = rd_addr_i;
  end

  assign collide = (|bit_en_i) && (wr_word_i == rd_word_o);
  assign merged  = (old_word_i & ~bit_en_i) | (wr_data_i & bit_en_i);
  // don't-care modes fall back to old data
  assign chosen  = (collide && ruw_e'(ruw_mode_i) == RUW_NEW) ? merged : old_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= chosen[32'(slice)*RD_W +: RD_W];
  end

  assign rd_data_o = rd_data_q;
  assign cur_slice = old_word_i[32'(slice)*RD_W +: RD_W];

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R7
  ruw_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && collide && ruw_e'(ruw_mode_i) == RUW_OLD) |=> rd_data_o == $past(cur_slice));

  // R8
  ruw_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && collide && ruw_e'(ruw_mode_i) == RUW_NEW) |=>
      ($stable(rd_addr_i) |-> rd_data_o == cur_slice));

  // R10
  no_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !collide) |=> rd_data_o == $past(cur_slice));
endmodule

// File: rtl/mwram_sdp.sv
module mwram_sdp #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 16,
  parameter int WR_K      = 2,
  parameter int RD_K      = 1,
  parameter int WR_MASK_W = 2,
  localparam int WORD_AW  = $clog2(DEPTH),
  localparam int WR_W     = WORD_W >> WR_K,
  localparam int RD_W     = WORD_W >> RD_K,
  localparam int WR_AW    = WORD_AW + WR_K,
  localparam int RD_AW    = WORD_AW + RD_K
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WR_AW-1:0]     wr_addr_i,
  input  logic [WR_W-1:0]      wr_data_i,
  input  logic [WR_MASK_W-1:0] wr_mask_i,
  input  logic                 rd_en_i,
  input  logic [RD_AW-1:0]     rd_addr_i,
  input  logic [1:0]           ruw_mode_i,
  output logic [RD_W-1:0]      rd_data_o
);
  logic [WORD_AW-1:0] wr_word, rd_word;
  logic [WORD_W-1:0]  bit_en, wdata, old_word;

  mwram_wr_align #(
    .WORD_W(WORD_W), .WORD_AW(WORD_AW), .WR_K(WR_K), .WR_MASK_W(WR_MASK_W)
  ) u_align (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_mask_i(wr_mask_i), .word_addr_o(wr_word), .bit_en_o(bit_en), .data_o(wdata)
  );

  mwram_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_word_i(wr_word), .bit_en_i(bit_en),
    .data_i(wdata), .rd_word_i(rd_word), .rd_word_o(old_word)
  );

  mwram_rd_port #(.WORD_W(WORD_W), .WORD_AW(WORD_AW), .RD_K(RD_K)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .ruw_mode_i(ruw_mode_i), .wr_word_i(wr_word), .bit_en_i(bit_en),
    .wr_data_i(wdata), .old_word_i(old_word), .rd_word_o(rd_word), .rd_data_o(rd_data_o)
  );

  // R2
  slice_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bit_en) <= WR_W);

  // R4
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> bit_en == '0);

  // R3
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_i == '0) |-> bit_en == '0);
endmodule

// File: tb/mwram_sdp_bench.sv
module mwram_sdp_bench;
  localparam int WORD_W = 32, DEPTH = 16, WR_K = 2, RD_K = 1, MW = 2;
  localparam int WR_W = WORD_W >> WR_K, RD_W = WORD_W >> RD_K;
  localparam int WR_AW = 4 + WR_K, RD_AW = 4 + RD_K, LANE_W = WR_W / MW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, chk_v = 1'b0;
  logic [WR_AW-1:0] wr_addr = '0;
  logic [WR_W-1:0]  wr_data = '0;
  logic [MW-1:0]    wr_mask = '0;
  logic [RD_AW-1:0] rd_addr = '0;
  logic [1:0]       mode = 2'd0;
  logic [RD_W-1:0]  rd_data;

  int errors = 0, checks = 0;
  logic [WORD_W-1:0] model [DEPTH];
  logic [RD_W-1:0] exp_q [$];
  string tag_q [$];
  logic [RD_W-1:0] last_rd = '0;

  always #2 clk = ~clk;

  mwram_sdp #(.WORD_W(WORD_W), .DEPTH(DEPTH), .WR_K(WR_K), .RD_K(RD_K), .WR_MASK_W(MW))
  u_mwram_sdp (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .ruw_mode_i(mode), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input logic [RD_W-1:0] act, input logic [RD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare one cycle after a checked operation
  always @(posedge clk) begin
    automatic logic fire = chk_v && rst_n;
    #1;
    if (fire) begin
      if (exp_q.size() == 0) check("queue", rd_data, 'x);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  function automatic logic [WORD_W-1:0] apply_wr(input logic [WORD_W-1:0] w,
      input int s, input logic [WR_W-1:0] d, input logic [MW-1:0] m);
    logic [WORD_W-1:0] r = w;
    for (int j = 0; j < MW; j++)
      if (m[j]) r[s*WR_W + j*LANE_W +: LANE_W] = d[j*LANE_W +: LANE_W];
    return r;
  endfunction

  // one cycle of stimulus; expected value pushed when chk is set
  task automatic op(input logic we, input int ww, input int ws, input logic [WR_W-1:0] wd,
      input logic [MW-1:0] wm, input logic re, input int rw, input int rs,
      input logic [1:0] md, input logic chk, input string tag);
    logic [WORD_W-1:0] old_w, new_w;
    logic [RD_W-1:0] exp;
    old_w = model[rw];
    new_w = (we && ww == rw) ? apply_wr(old_w, ws, wd, wm) : old_w;
    if (!re) exp = last_rd;
    else if (md == 2'd1) exp = new_w[rs*RD_W +: RD_W];
    else exp = old_w[rs*RD_W +: RD_W];
    if (re) last_rd = exp;
    if (we) model[ww] = apply_wr(model[ww], ws, wd, wm);
    wr_en = we; wr_addr = WR_AW'(ww * (1 << WR_K) + ws); wr_data = wd; wr_mask = wm;
    rd_en = re; rd_addr = RD_AW'(rw * (1 << RD_K) + rs); mode = md; chk_v = chk;
    if (chk) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; chk_v = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", rd_data, '0);
    op(0,0,0,0,0, 1,1,1, 0, 1, "R1 word reads zero");
    op(0,0,0,0,0, 1,9,0, 0, 1, "R1 word reads zero");
    for (int s = 0; s < 4; s++) op(1,2,s, 8'(8'h11 * (s+1)), 2'b11, 0,0,0, 0, 0, "");
    op(0,0,0,0,0, 1,2,0, 0, 1, "R5 low slice");
    op(0,0,0,0,0, 1,2,1, 0, 1, "R5 high slice");
    op(1,2,1,8'hAB,2'b11, 0,0,0, 0, 0, "");
    op(0,0,0,0,0, 1,2,0, 0, 1, "R2 written slice");
    op(0,0,0,0,0, 1,2,1, 0, 1, "R2 other slices kept");
    op(1,2,0,8'hCD,2'b10, 0,0,0, 0, 0, "");
    op(0,0,0,0,0, 1,2,0, 0, 1, "R3 masked lane kept");
    op(1,2,0,8'h0E,2'b01, 0,0,0, 0, 0, "");
    op(0,0,0,0,0, 1,2,0, 0, 1, "R3 low lane only");
    op(0,2,3,8'hEE,2'b11, 1,2,1, 0, 1, "R4 disabled write");
    op(0,0,0,0,0, 0,5,0, 0, 1, "R6 hold");
    op(1,9,0,8'h5A,2'b11, 0,9,0, 0, 1, "R6 hold under write");
    op(1,2,2,8'h99,2'b11, 1,2,1, 0, 1, "R7 old data on collision");
    op(0,0,0,0,0, 1,2,1, 0, 1, "R7 update visible");
    op(1,2,3,8'h77,2'b11, 1,2,1, 1, 1, "R8 new data merged");
    op(1,2,0,8'h55,2'b11, 1,2,1, 1, 1, "R8 other half unchanged");
    op(1,3,1,8'hEF,2'b01, 1,3,0, 1, 1, "R8 masked merge");
    op(1,4,1,8'h3C,2'b11, 1,4,0, 2, 0, "");
    op(0,0,0,0,0, 1,4,0, 0, 1, "R9 write completed");
    op(1,7,0,8'hF0,2'b11, 1,2,0, 1, 1, "R10 other word");
    op(1,7,2,8'h12,2'b11, 1,2,1, 0, 1, "R10 other word old mode");
    op(0,0,0,0,0, 1,7,0, 0, 1, "R10 other word written");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", RD_W'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule